// File: doc/BRIEF.md
# Real-Mode Address Former with Line-20 Gate

This block forms the physical bus address for legacy real-mode accesses. A 16-bit segment selector is shifted left by four bits and added to a zero-extended 16-bit offset, giving a 21-bit internal sum. The block registers that sum, and also registers a bus address that equals the sum except for address line 20. Line 20 passes only while a gate is open. While the gate is closed, any sum at or above 1 MB wraps back into low memory. For example, selector 0xFFFF with offset 0xFFFF gives the internal sum 0x10FFEF, which reaches the bus as 0x00FFEF. That is the same bus address as selector 0x0000 with offset 0xFFEF.

Two mechanisms on a simple I/O write/read bus control the gate. The first follows the style of a keyboard controller. The command 0xD1 is written to port 0x64, and the next accepted write to port 0x60 then loads the controller's output-port byte. The command port also reports an input-busy flag when it is read, and writes to the controller are refused while that flag is set. The second mechanism is a one-byte fast-gate register at port 0x92. Line 20 is passed when either mechanism has its bit 1 set.

Top module: `rm_addr_gate`

## Requirements
- R1: One cycle after a selector/offset pair is presented, `lin_sum` equals selector·16 plus the offset, 21 bits wide with no truncation (0xFFFF:0xFFFF gives 0x10FFEF).
- R2: `bus_addr` carries bits 19..0 of the same sum in the same cycle. Bit 20 of `bus_addr` is the sum's bit 20 when the gate was open before that clock edge, and 0 otherwise (0xFFFF:0xFFFF with the gate closed gives 0x00FFEF).
- R3: After a synchronous reset, both gate bits are 0 (so `a20_en` is 0), the controller is not busy, and `lin_sum`, `bus_addr` and `io_rdata` are 0.
- R4: `a20_en` is 1 exactly when bit 1 of the controller output-port byte is 1 or bit 1 of the fast-gate register is 1.
- R5: A write to port 0x92 stores data bit 1 into the fast-gate register at that clock edge. This write is never refused, even while the controller is busy.
- R6: A read of port 0x92 returns, one cycle later, the fast-gate bit in position 1 and 0 in every other bit.
- R7: An accepted write to port 0x60 that directly follows an accepted command 0xD1 on port 0x64 loads the output-port byte. Data 0xDF opens the gate and 0xDD closes it.
- R8: An accepted write to port 0x60 with no 0xD1 pending leaves the output port unchanged. Any other accepted command on port 0x64 cancels a pending 0xD1, and so does any accepted port-0x60 write.
- R9: Every accepted write to port 0x60 or 0x64 makes the controller busy for BUSY_CYC cycles. A read of port 0x64 returns the busy flag in bit 1 and 0 elsewhere, one cycle later.
- R10: A write to port 0x60 or 0x64 while the controller is busy is dropped. It changes neither the output port, nor the pending command, nor the busy count.
- R11: A read of any other port, and every cycle with no read, gives `io_rdata` equal to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_sel | input | 16 | Segment selector |
| seg_off | input | 16 | Offset within the segment |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 16 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| lin_sum | output | 21 | Registered internal 21-bit sum |
| bus_addr | output | 21 | Registered gated bus address |
| a20_en | output | 1 | Gate state (1 = line 20 passes) |

## Verification
The bench targets the top address, 0xFFFF:0xFFFF, with the gate both closed and open. A design that drops the carry would show 0x0FFEF on `lin_sum`. A design that ignores the gate would leave 0x10FFEF on the bus while the gate is closed. The controller sequence is probed with data written without a pending 0xD1, with a different command placed between 0xD1 and its data, and with data written while busy. A design that tracks the pending command loosely, or that accepts writes during the busy window, opens the gate when it must not. The fast-gate port is written while the controller is busy and read back with all data bits set, which catches a design that refuses that write or leaks the unused bits into the read data.

// File: rtl/rmg_pkg.sv
package rmg_pkg;
  localparam int SEL_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int IO_AW   = 16;
  localparam int DW      = 8;
  localparam int ADDR_W  = SEL_W + SHIFT + 1;
  localparam int GATE_BIT = 1;
  localparam int BUSY_BIT = 1;

  localparam logic [IO_AW-1:0] PORT_KBC_DATA = 16'h0060;
  localparam logic [IO_AW-1:0] PORT_KBC_CMD  = 16'h0064;
  localparam logic [IO_AW-1:0] PORT_FAST     = 16'h0092;
  localparam logic [DW-1:0]    CMD_WR_OUTP   = 8'hD1;

  function automatic logic [DW-1:0] one_bit(input int pos, input logic v);
    logic [DW-1:0] r;
    r = '0;
    r[pos] = v;
    return r;
  endfunction
endpackage

// File: rtl/rmg_addr_former.sv
module rmg_addr_former #(
  parameter int SEL_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  localparam int AW    = SEL_W + SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [OFF_W-1:0] off,
  input  logic             gate_open,
  output logic [AW-1:0]    sum_q,
  output logic [AW-1:0]    bus_q
);
  localparam int MASK_BIT = AW - 1;

  logic [AW-1:0] base_ext;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] sum_d;
  logic [AW-1:0] bus_d;

  always_comb begin
    base_ext = '0;
    base_ext[SHIFT +: SEL_W] = sel;
    off_ext  = '0;
    off_ext[OFF_W-1:0] = off;
    sum_d    = base_ext + off_ext;
  end

  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i == MASK_BIT) begin : g_gated
      assign bus_d[i] = sum_d[i] & gate_open;
    end else begin : g_pass
      assign bus_d[i] = sum_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      bus_q <= '0;
    end else begin
      sum_q <= sum_d;
      bus_q <= bus_d;
    end
  end
endmodule

// File: rtl/rmg_kbc_gate.sv
module rmg_kbc_gate #(
  parameter int IO_AW    = 16,
  parameter int DW       = 8,
  parameter int BUSY_CYC = 4,
  parameter int GATE_BIT = 1,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0060,
  parameter logic [IO_AW-1:0] CMD_PORT  = 16'h0064,
  parameter logic [DW-1:0]    WR_CMD    = 8'hD1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_port,
  input  logic [DW-1:0]    io_wdata,
  output logic             busy,
  output logic             gate_bit
);
  localparam int CW = (BUSY_CYC > 0) ? $clog2(BUSY_CYC + 1) : 1;

  logic          hit_cmd, hit_dat, acc_cmd, acc_dat;
  logic          pend_q;
  logic [DW-1:0] outp_q;

  assign hit_cmd = io_wr && (io_port == CMD_PORT);
  assign hit_dat = io_wr && (io_port == DATA_PORT);
  assign acc_cmd = hit_cmd && !busy;
  assign acc_dat = hit_dat && !busy;

  if (BUSY_CYC > 0) begin : g_busy
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (acc_cmd || acc_dat) begin
        cnt_q <= CW'(BUSY_CYC);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
    assign busy = (cnt_q != '0);
  end else begin : g_nobusy
    assign busy = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      outp_q <= '0;
    end else begin
      if (acc_cmd) begin
        pend_q <= (io_wdata == WR_CMD);
      end else if (acc_dat) begin
        pend_q <= 1'b0;
      end
      if (acc_dat && pend_q) begin
        outp_q <= io_wdata;
      end
    end
  end

  assign gate_bit = outp_q[GATE_BIT];
endmodule

// File: rtl/rmg_fast_gate.sv
module rmg_fast_gate #(
  parameter int IO_AW    = 16,
  parameter int DW       = 8,
  parameter int GATE_BIT = 1,
  parameter logic [IO_AW-1:0] FAST_PORT = 16'h0092
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_port,
  input  logic [DW-1:0]    io_wdata,
  output logic             fast_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fast_bit <= 1'b0;
    end else if (io_wr && (io_port == FAST_PORT)) begin
      fast_bit <= io_wdata[GATE_BIT];
    end
  end
endmodule

// File: rtl/rm_addr_gate.sv
module rm_addr_gate
  import rmg_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [OFF_W-1:0]  seg_off,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_port,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic [ADDR_W-1:0] lin_sum,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              a20_en
);
  logic kbc_busy;
  logic kbc_gate;
  logic fast_bit;

  rmg_kbc_gate #(
    .IO_AW(IO_AW), .DW(DW), .BUSY_CYC(BUSY_CYC), .GATE_BIT(GATE_BIT),
    .DATA_PORT(PORT_KBC_DATA), .CMD_PORT(PORT_KBC_CMD), .WR_CMD(CMD_WR_OUTP)
  ) u_kbc (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port),
    .io_wdata(io_wdata), .busy(kbc_busy), .gate_bit(kbc_gate)
  );

  rmg_fast_gate #(
    .IO_AW(IO_AW), .DW(DW), .GATE_BIT(GATE_BIT), .FAST_PORT(PORT_FAST)
  ) u_fast (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port),
    .io_wdata(io_wdata), .fast_bit(fast_bit)
  );

  assign a20_en = kbc_gate | fast_bit;

  rmg_addr_former #(
    .SEL_W(SEL_W), .OFF_W(OFF_W), .SHIFT(SHIFT)
  ) u_addr (
    .clk(clk), .rst(rst), .sel(seg_sel), .off(seg_off),
    .gate_open(a20_en), .sum_q(lin_sum), .bus_q(bus_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd && (io_port == PORT_KBC_CMD)) begin
      io_rdata <= one_bit(BUSY_BIT, kbc_busy);
    end else if (io_rd && (io_port == PORT_FAST)) begin
      io_rdata <= one_bit(GATE_BIT, fast_bit);
    end else begin
      io_rdata <= '0;
    end
  end
endmodule

// File: rtl/rm_addr_gate_chk.sv
module rm_addr_gate_chk
  import rmg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  seg_sel,
  input logic [OFF_W-1:0]  seg_off,
  input logic              io_wr,
  input logic [IO_AW-1:0]  io_port,
  input logic [DW-1:0]     io_wdata,
  input logic [ADDR_W-1:0] lin_sum,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              a20_en,
  input logic              kbc_busy
);
  p_sum_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> lin_sum == ({1'b0, $past(seg_sel), 4'h0} + {5'h0, $past(seg_off)}));

  p_low_bits_r2: assert property (@(posedge clk) disable iff (rst)
    bus_addr[ADDR_W-2:0] == lin_sum[ADDR_W-2:0]);

  p_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bus_addr[ADDR_W-1]) |-> $past(a20_en));

  p_open_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a20_en) && lin_sum[ADDR_W-1]) |-> bus_addr[ADDR_W-1]);

  p_reset_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!a20_en && lin_sum == '0 && bus_addr == '0));

  p_fast_set_r5: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_port == PORT_FAST && io_wdata[GATE_BIT]) |=> a20_en);

  p_busy_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (kbc_busy && io_wr && io_port == PORT_KBC_DATA) |=> $stable(a20_en));
endmodule

bind rm_addr_gate rm_addr_gate_chk u_rm_addr_gate_chk (
  .clk(clk), .rst(rst), .seg_sel(seg_sel), .seg_off(seg_off),
  .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
  .lin_sum(lin_sum), .bus_addr(bus_addr), .a20_en(a20_en),
  .kbc_busy(kbc_busy)
);

// File: tb/rm_addr_gate_bench.sv
module rm_addr_gate_bench;
  localparam int B = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] seg_sel = '0, seg_off = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_port = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [20:0] lin_sum, bus_addr;
  logic        a20_en;

  int tests = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  int          m_busy = 0;
  bit          m_pend = 0, m_out1 = 0, m_fg = 0;
  logic [20:0] m_sum = '0, m_bus = '0;
  logic [7:0]  m_rd = '0;

  always #2.5 clk = ~clk;

  rm_addr_gate #(.BUSY_CYC(B)) u_rm_addr_gate (
    .clk(clk), .rst(rst), .seg_sel(seg_sel), .seg_off(seg_off),
    .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .lin_sum(lin_sum), .bus_addr(bus_addr), .a20_en(a20_en)
  );

  always @(posedge clk) begin
    int s;
    bit acc;
    started = 1;
    if (rst) begin
      m_busy = 0; m_pend = 0; m_out1 = 0; m_fg = 0;
      m_sum = '0; m_bus = '0; m_rd = '0;
    end else begin
      s = int'(seg_sel) * 16 + int'(seg_off);
      m_sum = 21'(s);
      m_bus = (m_out1 || m_fg) ? 21'(s) : 21'(s % 1048576);
      if (io_rd && io_port == 16'h0064)      m_rd = (m_busy > 0) ? 8'h02 : 8'h00;
      else if (io_rd && io_port == 16'h0092) m_rd = m_fg ? 8'h02 : 8'h00;
      else                                    m_rd = 8'h00;
      acc = io_wr && (io_port == 16'h0060 || io_port == 16'h0064) && m_busy == 0;
      if (acc) m_busy = B;
      else if (m_busy > 0) m_busy = m_busy - 1;
      if (acc && io_port == 16'h0064) m_pend = (io_wdata == 8'hD1);
      if (acc && io_port == 16'h0060) begin
        if (m_pend) m_out1 = io_wdata[1];
        m_pend = 0;
      end
      if (io_wr && io_port == 16'h0092) m_fg = io_wdata[1];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1 lin_sum model", 32'(lin_sum), 32'(m_sum));
      chk("R2 bus_addr model", 32'(bus_addr), 32'(m_bus));
      chk("R4 a20_en model", 32'(a20_en), 32'(m_out1 | m_fg));
      chk("R9/R6/R11 io_rdata model", 32'(io_rdata), 32'(m_rd));
    end
  end

  task automatic io_write(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_port = p; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] p, input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_rd = 1'b1; io_port = p;
    @(negedge clk);
    io_rd = 1'b0;
    chk(tag, 32'(io_rdata), 32'(exp));
  endtask

  task automatic addr(input logic [15:0] s, input logic [15:0] o,
                      input logic [20:0] exp_sum, input logic [20:0] exp_bus, input string tag);
    @(negedge clk);
    seg_sel = s; seg_off = o;
    @(negedge clk);
    chk({tag, " sum"}, 32'(lin_sum), 32'(exp_sum));
    chk({tag, " bus"}, 32'(bus_addr), 32'(exp_bus));
  endtask

  task automatic idle();
    repeat (B + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R3 reset a20_en", 32'(a20_en), 0);
    chk("R3 reset lin_sum", 32'(lin_sum), 0);
    chk("R3 reset io_rdata", 32'(io_rdata), 0);
    io_read(16'h0064, 8'h00, "R3 reset not busy");

    addr(16'hFFFF, 16'hFFFF, 21'h10FFEF, 21'h00FFEF, "R1 R2 top wraps closed");
    addr(16'h0000, 16'hFFEF, 21'h00FFEF, 21'h00FFEF, "R2 alias low");
    addr(16'h1234, 16'h5678, 21'h0179B8, 21'h0179B8, "R1 mid");

    io_write(16'h0060, 8'hDF);
    chk("R8 data without command", 32'(a20_en), 0);
    idle();

    io_write(16'h0064, 8'hD1);
    io_read(16'h0064, 8'h02, "R9 busy after command");
    io_write(16'h0060, 8'hDF);
    chk("R10 data while busy dropped", 32'(a20_en), 0);
    idle();
    io_read(16'h0064, 8'h00, "R9 busy expired");
    io_write(16'h0060, 8'hDF);
    chk("R7 gate opened", 32'(a20_en), 1);
    addr(16'hFFFF, 16'hFFFF, 21'h10FFEF, 21'h10FFEF, "R2 top open");
    idle();

    io_write(16'h0064, 8'hD1); idle();
    io_write(16'h0064, 8'hAD); idle();
    io_write(16'h0060, 8'hDD);
    chk("R8 other command cancels", 32'(a20_en), 1);
    idle();

    io_write(16'h0064, 8'hD1); idle();
    io_write(16'h0060, 8'hDD);
    chk("R7 gate closed", 32'(a20_en), 0);

    io_write(16'h0092, 8'h02);
    chk("R5 fast write during busy", 32'(a20_en), 1);
    io_read(16'h0092, 8'h02, "R6 fast readback");
    io_write(16'h0092, 8'hFF);
    io_read(16'h0092, 8'h02, "R6 unused bits zero");
    addr(16'hF800, 16'h8000, 21'h100000, 21'h100000, "R4 R2 open via fast");
    io_write(16'h0092, 8'hFD);
    chk("R5 fast bit cleared", 32'(a20_en), 0);
    addr(16'hF800, 16'h8000, 21'h100000, 21'h000000, "R2 wrap to zero");
    io_read(16'h0071, 8'h00, "R11 other port");
    idle();

    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule